// File: doc/BRIEF.md
# Interrupt Vector Table Engine

This block turns per-source interrupt events into memory writes. Each vector has its own table entry. An entry holds a 64-bit target address, a 32-bit data word and a mask bit, so every interrupt can be aimed at a different processor. Software programs the entries through a word-wide register port. The same port also holds a single mask that covers the whole function and a read-only view of the pending bits.

An event pulse on a vector sets that vector's pending bit. A vector can be sent when it is pending, not masked itself, and the function mask is clear. A round-robin arbiter picks one sendable vector at a time. The engine copies that entry's address and data into an output register and presents them as one memory-write request with a valid/ready handshake. The pending bit clears when the request is accepted. The table depth is a parameter and may go up to 2048 vectors.

Top module: `irq_vector_table`

## Requirements
- R1: After reset, every vector mask reads 1, the function mask reads 0, all pending bits read 0 and msg_valid is low.
- R2: Register word 4*i+0 holds entry i's address low word, 4*i+1 the address high word, 4*i+2 the data word and 4*i+3 the control word, whose bit 0 is the vector mask and whose other bits read 0. A read returns its word on reg_rdata one cycle after reg_rd, and reg_rdata holds when no read is made.
- R3: Word 4*N holds the function mask in bit 0. Words 4*N+1+k show pending bits 32k..32k+31, with bit j belonging to vector 32k+j. Writes to the pending words are ignored.
- R4: An event pulse sets the vector's pending bit. While the vector mask or the function mask is set, no request is issued for that vector.
- R5: A request for vector v carries msg_addr = {address high, address low} and msg_data = the data word of entry v, and msg_vec = v.
- R6: Once msg_valid is high, msg_addr, msg_data and msg_vec stay stable until msg_ready is seen. The vector's pending bit clears when the request is accepted.
- R7: A vector that is already pending is sent once its mask is cleared.
- R8: After serving vector v, the arbiter serves the first sendable vector above v, wrapping from N-1 to 0. After reset the search starts at vector 0.
- R9: Address and data are captured when the request is issued. A software write to the entry while the request is outstanding does not change it.
- R10: An event on a vector in the same cycle as the acceptance of that vector's request leaves the pending bit set, so a second request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| evt | input | NUM_VEC | Per-vector event pulses |
| msg_valid | output | 1 | Memory-write request valid |
| msg_ready | input | 1 | Memory-write request accepted |
| msg_addr | output | 64 | Write target address |
| msg_data | output | 32 | Write data word |
| msg_vec | output | VW | Index of the vector being sent |

## Verification
The assertions check several things on every cycle:
- The outgoing request holds still until it is accepted.
- A request is only issued for a pending, unmasked vector while the function mask is clear.
- Events set their pending bits, and an acceptance clears the bit.
- The arbiter grant is one-hot.
- Control writes land in the mask.
- Read data holds when no read is made.

Only the bench scenarios can show the following:
- The register map and the read-only pending words.
- The full round-robin order after a given last-served vector.
- That a table rewrite during an outstanding request leaves the request untouched.
- That an event coinciding with acceptance produces a second request.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } word_sel_e;

  // Joins the two address halves into the outgoing 64-bit target.
  function automatic logic [63:0] join_addr(input logic [31:0] hi, input logic [31:0] lo);
    return {hi, lo};
  endfunction

  // Control word as seen by software: only bit 0 (mask) is implemented.
  function automatic logic [31:0] ctrl_word(input logic mask);
    return {31'b0, mask};
  endfunction

endpackage

// File: rtl/ivt_store.sv
module ivt_store
  import ivt_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int VW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VW-1:0]      wr_vec,
  input  word_sel_e          wr_sel,
  input  logic [31:0]        wdata,
  input  logic [VW-1:0]      rd_vec,
  input  word_sel_e          rd_sel,
  output logic [31:0]        rd_word,
  input  logic [VW-1:0]      iss_vec,
  output logic [63:0]        iss_addr,
  output logic [31:0]        iss_data,
  output logic [NUM_VEC-1:0] mask_vec
);

  logic [31:0]        lo_q  [NUM_VEC];
  logic [31:0]        hi_q  [NUM_VEC];
  logic [31:0]        dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
      end
      mask_q <= '1;
    end else if (wr_en) begin
      case (wr_sel)
        W_ADDR_LO: lo_q[wr_vec]   <= wdata;
        W_ADDR_HI: hi_q[wr_vec]   <= wdata;
        W_DATA:    dat_q[wr_vec]  <= wdata;
        W_CTRL:    mask_q[wr_vec] <= wdata[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      W_ADDR_LO: rd_word = lo_q[rd_vec];
      W_ADDR_HI: rd_word = hi_q[rd_vec];
      W_DATA:    rd_word = dat_q[rd_vec];
      default:   rd_word = ctrl_word(mask_q[rd_vec]);
    endcase
  end

  assign iss_addr = join_addr(hi_q[iss_vec], lo_q[iss_vec]);
  assign iss_data = dat_q[iss_vec];
  assign mask_vec = mask_q;

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == W_CTRL) |=> (mask_vec[$past(wr_vec)] == $past(wdata[0])));

endmodule

// File: rtl/ivt_pend.sv
module ivt_pend #(
  parameter int NUM_VEC = 16,
  parameter int VW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] evt,
  input  logic               clr_en,
  input  logic [VW-1:0]      clr_vec,
  output logic [NUM_VEC-1:0] pend
);

  logic [NUM_VEC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_vec] = 1'b1;
  end

  // A set arriving with a clear wins, so no event is lost.
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | evt;
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_chk
    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> pend[g]);
  end

  p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !evt[clr_vec]) |=> !pend[$past(clr_vec)]);

  p_evt_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && evt[clr_vec]) |=> pend[$past(clr_vec)]);

endmodule

// File: rtl/ivt_rr_arb.sv
module ivt_rr_arb #(
  parameter int NUM_VEC = 16,
  parameter int VW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req,
  input  logic               adv,
  output logic               any,
  output logic [VW-1:0]      win_idx,
  output logic [NUM_VEC-1:0] grant
);

  logic [VW-1:0] last_q;

  // Searches upward from the vector after 'last', wrapping at NUM_VEC.
  function automatic logic [VW:0] rr_pick(input logic [NUM_VEC-1:0] r,
                                          input logic [VW-1:0] last);
    logic          found;
    logic [VW-1:0] idx;
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= NUM_VEC; k++) begin
      int c;
      c = int'(last) + k;
      if (c >= NUM_VEC) c = c - NUM_VEC;
      if (!found && r[c]) begin
        found = 1'b1;
        idx   = VW'(c);
      end
    end
    return {found, idx};
  endfunction

  logic [VW:0] pick;

  always_comb begin
    pick    = rr_pick(req, last_q);
    any     = pick[VW];
    win_idx = pick[VW-1:0];
    grant   = '0;
    if (any) grant[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= VW'(NUM_VEC - 1);
    else if (adv) last_q <= win_idx;
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

endmodule

// File: rtl/irq_vector_table.sv
module irq_vector_table
  import ivt_pkg::*;
#(
  parameter int  NUM_VEC   = 16,
  localparam int VW        = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int PW        = (NUM_VEC + 31) / 32,
  localparam int CTRL_IDX  = 4 * NUM_VEC,
  localparam int PEND_BASE = CTRL_IDX + 1,
  localparam int REG_WORDS = PEND_BASE + PW,
  localparam int AW        = $clog2(REG_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] evt,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [VW-1:0]      msg_vec
);

  // Register decode
  logic          hit_table, hit_ctrl;
  logic [VW-1:0] reg_vec;
  word_sel_e     reg_sel;

  assign hit_table = (int'(reg_addr) < CTRL_IDX);
  assign hit_ctrl  = (int'(reg_addr) == CTRL_IDX);
  assign reg_vec   = reg_addr[VW+1:2];
  assign reg_sel   = word_sel_e'(reg_addr[1:0]);

  logic fmask_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                 fmask_q <= 1'b0;
    else if (reg_wr && hit_ctrl) fmask_q <= reg_wdata[0];
  end

  // Table, pending array and arbiter
  logic [31:0]        tbl_word;
  logic [63:0]        iss_addr;
  logic [31:0]        iss_data;
  logic [NUM_VEC-1:0] vmask, pend, sendable, grant;
  logic               arb_any, issue_fire, accept;
  logic [VW-1:0]      win_idx;

  ivt_store #(.NUM_VEC(NUM_VEC), .VW(VW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr && hit_table),
    .wr_vec   (reg_vec),
    .wr_sel   (reg_sel),
    .wdata    (reg_wdata),
    .rd_vec   (reg_vec),
    .rd_sel   (reg_sel),
    .rd_word  (tbl_word),
    .iss_vec  (win_idx),
    .iss_addr (iss_addr),
    .iss_data (iss_data),
    .mask_vec (vmask)
  );

  ivt_pend #(.NUM_VEC(NUM_VEC), .VW(VW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .clr_en  (accept),
    .clr_vec (msg_vec),
    .pend    (pend)
  );

  assign sendable = pend & ~vmask & {NUM_VEC{~fmask_q}};

  ivt_rr_arb #(.NUM_VEC(NUM_VEC), .VW(VW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (sendable),
    .adv     (issue_fire),
    .any     (arb_any),
    .win_idx (win_idx),
    .grant   (grant)
  );

  // Outgoing request register: sampled at issue, held until accepted
  assign issue_fire = !msg_valid && arb_any;
  assign accept     = msg_valid && msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else if (issue_fire) begin
      msg_valid <= 1'b1;
      msg_addr  <= iss_addr;
      msg_data  <= iss_data;
      msg_vec   <= win_idx;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end

  // Read path
  logic [PW*32-1:0] pend_pad;
  logic [31:0]      rd_mux;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend;
    rd_mux = '0;
    if (hit_table)     rd_mux = tbl_word;
    else if (hit_ctrl) rd_mux = {31'b0, fmask_q};
    else begin
      for (int k = 0; k < PW; k++)
        if (int'(reg_addr) == PEND_BASE + k) rd_mux = pend_pad[k*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  p_msg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec)));

  p_issue_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (pend[win_idx] && !vmask[win_idx] && !fmask_q));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/irq_vector_table_bench.sv
module irq_vector_table_bench;

  localparam int N     = 8;
  localparam int B_VW  = 3;
  localparam int B_AW  = 6;
  localparam int CTRLW = 4 * N;
  localparam int PENDW = 4 * N + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [B_AW-1:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [N-1:0]    evt = '0;
  logic            msg_valid, msg_ready = 1'b0;
  logic [63:0]     msg_addr;
  logic [31:0]     msg_data;
  logic [B_VW-1:0] msg_vec;

  always #4 clk = ~clk;

  irq_vector_table #(.NUM_VEC(N)) u_irq_vector_table (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt(evt), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] e_lo [N];
  logic [31:0] e_hi [N];
  logic [31:0] e_dat[N];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = B_AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = B_AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_valid(input string req);
    int t = 0;
    while (!msg_valid && t < 60) begin @(negedge clk); t++; end
    chk({req, " request appears"}, 64'(msg_valid), 64'd1);
  endtask

  task automatic take(input string req, input int v);
    wait_valid(req);
    chk({req, " vector"}, 64'(msg_vec), 64'(v));
    chk({req, " address"}, msg_addr, {e_hi[v], e_lo[v]});
    chk({req, " data"}, 64'(msg_data), 64'(e_dat[v]));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic idle_check(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, 64'(msg_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] a0, d0, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 msg_valid", 64'(msg_valid), 64'd0);
    for (int i = 0; i < N; i++) begin
      rd(4*i+3, d); chk("R1 vector mask", 64'(d), 64'd1);
      rd(4*i+2, d); chk("R1 data word", 64'(d), 64'd0);
    end
    rd(CTRLW, d); chk("R1 function mask", 64'(d), 64'd0);
    rd(PENDW, d); chk("R1 pending", 64'(d), 64'd0);

    // R2: program entries and read every word back
    for (int i = 0; i < N; i++) begin
      e_lo[i] = 32'h1000_0000 + 32'(i * 16);
      e_hi[i] = 32'h0000_00A0 + 32'(i);
      e_dat[i] = 32'h0000_D000 + 32'(i);
      wr(4*i+0, e_lo[i]); wr(4*i+1, e_hi[i]); wr(4*i+2, e_dat[i]);
      wr(4*i+3, 32'hFFFF_FFFF);
    end
    for (int i = 0; i < N; i++) begin
      rd(4*i+0, d); chk("R2 address low", 64'(d), 64'(e_lo[i]));
      rd(4*i+1, d); chk("R2 address high", 64'(d), 64'(e_hi[i]));
      rd(4*i+2, d); chk("R2 data", 64'(d), 64'(e_dat[i]));
      rd(4*i+3, d); chk("R2 control only bit 0", 64'(d), 64'd1);
    end

    // R4: masked events only set pending
    evt = 8'b0000_1010; @(negedge clk); evt = '0;
    idle_check("R4 masked vector stays silent", 6);
    rd(PENDW, d); chk("R4 pending bits set", 64'(d), 64'h0A);

    // R3: pending word is read-only
    wr(PENDW, 32'h0000_0000);
    wr(PENDW, 32'hFFFF_FFFF);
    rd(PENDW, d); chk("R3 pending write ignored", 64'(d), 64'h0A);

    // R7 / R5 / R6 / R9: unmask vector 3 while ready is low
    wr(4*3+3, 32'h0);
    wait_valid("R7 unmasked pending vector");
    chk("R5 vector", 64'(msg_vec), 64'd3);
    chk("R5 address", msg_addr, {e_hi[3], e_lo[3]});
    chk("R5 data", 64'(msg_data), 64'(e_dat[3]));
    a0 = msg_addr; d0 = 64'(msg_data); v0 = 64'(msg_vec);
    repeat (3) @(negedge clk);
    chk("R6 held address", msg_addr, a0);
    chk("R6 held valid", 64'(msg_valid), 64'd1);
    wr(4*3+2, 32'h5555_0003);
    wr(4*3+0, 32'h7777_0000);
    chk("R9 data unchanged in flight", 64'(msg_data), d0);
    chk("R9 address unchanged in flight", msg_addr, a0);
    chk("R6 held vector", 64'(msg_vec), v0);
    e_dat[3] = 32'h5555_0003; e_lo[3] = 32'h7777_0000;
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    @(negedge clk);
    rd(PENDW, d); chk("R6 pending cleared on accept", 64'(d), 64'h02);

    // R4 function mask, then R8 round-robin after vector 3
    wr(CTRLW, 32'h1);
    for (int i = 0; i < N; i++) wr(4*i+3, 32'h0);
    evt = '1; @(negedge clk); evt = '0;
    idle_check("R4 function mask silences all", 6);
    rd(PENDW, d); chk("R4 all pending", 64'(d), 64'hFF);
    rd(CTRLW, d); chk("R3 function mask readback", 64'(d), 64'd1);
    wr(CTRLW, 32'h0);
    for (int k = 1; k <= N; k++) take("R8 round-robin order", (3 + k) % N);
    @(negedge clk);
    rd(PENDW, d); chk("R6 all pending cleared", 64'(d), 64'h00);
    idle_check("R8 nothing left to send", 4);

    // R10: event on the accepting cycle re-arms the vector
    evt = 8'b0010_0000; @(negedge clk); evt = '0;
    wait_valid("R10 first request");
    chk("R10 first vector", 64'(msg_vec), 64'd5);
    msg_ready = 1'b1; evt = 8'b0010_0000;
    @(negedge clk);
    msg_ready = 1'b0; evt = '0;
    take("R10 second request", 5);
    @(negedge clk);
    rd(PENDW, d); chk("R10 pending finally clear", 64'(d), 64'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule